// File: doc/BRIEF.md
# Prescaled 16-bit Down-Counting Timer

This block is a 16-bit down-counter whose count enable comes from one of two places. In timer mode, a free-running 8-bit prescaler divides one of two synchronous source tick streams by 1, 4, 32 or 256. Each pass through the selected tap produces a single-cycle count enable. In event mode, edges of an external input drive the count instead. That input is synchronized, optionally filtered against noise by a slow sample tick, and then edge-detected with a selectable polarity.

Software reaches the block through a small write port that has two locations: a control word and a reload value. The live count is always visible on an output. When the count is at zero, the next count enable reloads the counter and raises a one-cycle underflow pulse. Counter behaviour is identical in both modes; only the origin of the count enable differs.

Top module: `ptmr_top`

## Requirements
- R1: Each count enable lowers the 16-bit count by exactly one; a running counter never moves by any other step except at reload.
- R2: Control bits [2:1] pick the division: 00 = every source tick, 01 = every 4th, 10 = every 32nd, 11 = every 256th. The prescaler is cleared while stopped, so after starting, the first enable comes on the N-th selected tick.
- R3: Control bit 0 selects the tick source: 0 = src0_tick, 1 = src1_tick. Ticks on the unselected source have no effect. The bit resets to 0.
- R4: While control bit 3 (run) is 0, no count enable occurs. The count holds and no underflow pulse is produced.
- R5: With control bit 4 set (event mode), edges of ext_in are the only count enables. Source ticks and the division setting have no effect.
- R6: Control bit 5 selects the counted edge of ext_in: 0 = falling edge, 1 = rising edge. The other edge is not counted.
- R7: With control bit 6 set, a level change of ext_in is accepted only once it is seen at two consecutive smp_tick samples. A glitch that misses a sample, or that is caught by only one sample, is not counted.
- R8: A count enable while the count is 0 loads the reload value and raises underflow_o for exactly one cycle.
- R9: A write to address 1 stores the reload value. If run is 0, the count takes this value on the next cycle. If run is 1, the count is untouched and the new value is used at the next reload.
- R10: After reset the count is 0, underflow_o is 0, and every control bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src0_tick | input | 1 | First source clock enable pulse |
| src1_tick | input | 1 | Second source clock enable pulse |
| smp_tick | input | 1 | Noise-filter sample enable (slow rate) |
| ext_in | input | 1 | External event input (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control word, 1 = reload value |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Live counter value |
| underflow_o | output | 1 | One-cycle pulse at reload from zero |

## Verification
Timer mode is swept over every combination of source select and division ratio. Each run uses a fixed tick burst, while the unselected source carries interleaved noise ticks. The expected count and underflow total are derived arithmetically from the burst length, so a wrong tap, a wrong source or a missed prescaler clear each give a different final value. Event mode is driven with alternating edges under both polarities, with source ticks fed alongside to show they are ignored. With the filter enabled, a glitch that misses every sample and a glitch caught by a single sample are each shown not to count, while a clean level change does count. Reload writes are made both while stopped and while running, which separates an immediate load from a deferred one.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [1:0] {
        DIV_1   = 2'b00,
        DIV_4   = 2'b01,
        DIV_32  = 2'b10,
        DIV_256 = 2'b11
    } ratio_e;

    typedef struct packed {
        logic   filt_en;   // bit 6
        logic   rise_pol;  // bit 5
        logic   evt_mode;  // bit 4
        logic   run;       // bit 3
        ratio_e ratio;     // bits 2:1
        logic   src_sel;   // bit 0
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_RLD  = 1'b1;

endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
    import ptmr_pkg::*;
#(
    parameter int unsigned TAP_B = 2,
    parameter int unsigned TAP_C = 5,
    parameter int unsigned TAP_D = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  logic   src_sel,
    input  ratio_e ratio,
    input  logic   src0_tick,
    input  logic   src1_tick,
    output logic   pre_en
);
    localparam int unsigned DIV_W = TAP_D;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    tick;
    logic    tap_hit;

    always_comb begin
        st_d = st_q;
        tick = src_sel ? src1_tick : src0_tick;
        unique case (ratio)
            DIV_1:   tap_hit = 1'b1;
            DIV_4:   tap_hit = &st_q.div[TAP_B-1:0];
            DIV_32:  tap_hit = &st_q.div[TAP_C-1:0];
            default: tap_hit = &st_q.div[TAP_D-1:0];
        endcase
        pre_en = run && tick && tap_hit;
        if (!run) begin
            st_d.div = '0;
        end else if (tick) begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ptmr_evt_in.sv
module ptmr_evt_in #(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic smp_tick,
    input  logic filt_en,
    input  logic rise_pol,
    input  logic run,
    output logic evt_en
);
    typedef struct packed {
        logic sync1;
        logic sync2;
        logic samp;
        logic filt;
        logic prev;
    } evt_st_t;

    evt_st_t st_d, st_q;
    logic    level;
    logic    edge_hit;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = ext_in;
        st_d.sync2 = st_q.sync1;
        if (smp_tick) begin
            st_d.samp = st_q.sync2;
            if (st_q.sync2 == st_q.samp) begin
                st_d.filt = st_q.samp;
            end
        end
        level     = filt_en ? st_q.filt : st_q.sync2;
        st_d.prev = level;
        edge_hit  = rise_pol ? (level && !st_q.prev) : (!level && st_q.prev);
        evt_en    = run && edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync1: IDLE_LVL, sync2: IDLE_LVL, samp: IDLE_LVL,
                      filt: IDLE_LVL, prev: IDLE_LVL};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             ld_now,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] rld_val,
    output logic [CNT_W-1:0] count,
    output logic             ufl
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ufl;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ufl = 1'b0;
        if (ld_now) begin
            st_d.cnt = ld_val;
        end else if (cnt_en) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = rld_val;
                st_d.ufl = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign ufl   = st_q.ufl;

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src0_tick,
    input  logic             src1_tick,
    input  logic             smp_tick,
    input  logic             ext_in,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             underflow_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] rld;
    } reg_st_t;

    reg_st_t    rg_d, rg_q;
    logic       ld_now;
    logic       pre_en;
    logic       evt_en;
    logic       cnt_en;
    logic       run_act;
    logic       evt_act;

    always_comb begin
        rg_d   = rg_q;
        ld_now = 1'b0;
        if (wr_en) begin
            if (wr_addr == ADDR_CTRL) begin
                rg_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
            end else begin
                rg_d.rld = wr_data;
                ld_now   = !rg_q.ctrl.run;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign run_act = rg_q.ctrl.run;
    assign evt_act = rg_q.ctrl.evt_mode;

    ptmr_prescale u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_act && !evt_act),
        .src_sel   (rg_q.ctrl.src_sel),
        .ratio     (rg_q.ctrl.ratio),
        .src0_tick (src0_tick),
        .src1_tick (src1_tick),
        .pre_en    (pre_en)
    );

    ptmr_evt_in u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_in   (ext_in),
        .smp_tick (smp_tick),
        .filt_en  (rg_q.ctrl.filt_en),
        .rise_pol (rg_q.ctrl.rise_pol),
        .run      (run_act && evt_act),
        .evt_en   (evt_en)
    );

    assign cnt_en = evt_act ? evt_en : pre_en;

    ptmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .ld_now  (ld_now),
        .ld_val  (wr_data),
        .rld_val (rg_q.rld),
        .count   (count_o),
        .ufl     (underflow_o)
    );

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_q,
    input logic             evt_q,
    input logic             src_sel_q,
    input logic             src0_tick,
    input logic             src1_tick,
    input logic             pre_en,
    input logic             evt_en,
    input logic             wr_en,
    input logic [CNT_W-1:0] rld_q,
    input logic [CNT_W-1:0] count_o,
    input logic             underflow_o
);

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> (count_o == $past(count_o) || count_o == $past(count_o) - 1'b1 || underflow_o)); // R1

    AST_TICK_FROM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |-> (src_sel_q ? src1_tick : src0_tick)); // R3

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_en) |=> ($stable(count_o) && !underflow_o)); // R4

    AST_EVT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && evt_q && !evt_en) |=> $stable(count_o)); // R5

    AST_UFL_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> ($past(count_o) == '0 && count_o == $past(rld_q))); // R8

    AST_UFL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> (!underflow_o || $past(rld_q) == '0)); // R8

endmodule

bind ptmr_top ptmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_q       (run_act),
    .evt_q       (evt_act),
    .src_sel_q   (rg_q.ctrl.src_sel),
    .src0_tick   (src0_tick),
    .src1_tick   (src1_tick),
    .pre_en      (pre_en),
    .evt_en      (evt_en),
    .wr_en       (wr_en),
    .rld_q       (rg_q.rld),
    .count_o     (count_o),
    .underflow_o (underflow_o)
);

// File: tb/ptmr_top_test.sv
module ptmr_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src0_tick = 1'b0;
    logic        src1_tick = 1'b0;
    logic        smp_tick = 1'b0;
    logic        ext_in = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_o;
    logic        underflow_o;

    int n_chk = 0;
    int n_bad = 0;
    int ufl_seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ptmr_top uut (
        .clk(clk), .rst_n(rst_n), .src0_tick(src0_tick), .src1_tick(src1_tick),
        .smp_tick(smp_tick), .ext_in(ext_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count_o), .underflow_o(underflow_o)
    );

    always @(negedge clk) if (rst_n && underflow_o) ufl_seen++;

    // control word bits: 0 src, 2:1 ratio, 3 run, 4 event, 5 rising, 6 filter
    localparam logic [15:0] RUN  = 16'h0008;
    localparam logic [15:0] EVT  = 16'h0010;
    localparam logic [15:0] RISE = 16'h0020;
    localparam logic [15:0] FILT = 16'h0040;

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int sel, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src0_tick = (sel == 0); src1_tick = (sel == 1);
            @(negedge clk);
            src0_tick = (sel == 1); src1_tick = (sel == 0);
        end
        @(negedge clk);
        src0_tick = 1'b0; src1_tick = 1'b0;
    endtask

    task automatic ext_set(input logic v);
        @(negedge clk);
        ext_in = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic smp();
        @(negedge clk);
        smp_tick = 1'b1;
        @(negedge clk);
        smp_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int u0;
        int c0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 count after reset", count_o, 0);
        check("R10 underflow after reset", underflow_o, 0);
        rst_n = 1'b1;
        ticks(0, 10);
        check("R10 control zero, no counting", count_o, 0);

        // R2 R3 R8 sweep over source and ratio
        for (int sel = 0; sel < 2; sel++) begin
            for (int r = 0; r < 4; r++) begin
                int dv;
                int k;
                int rl;
                int nt;
                logic [15:0] cw;
                dv = (r == 0) ? 1 : (r == 1) ? 4 : (r == 2) ? 32 : 256;
                rl = 5 + r;
                nt = 300 + 13 * r;
                cw = 16'(sel) | 16'(r << 1);
                wr(1'b0, cw);
                wr(1'b1, 16'(rl));
                check($sformatf("R9 stopped load sel%0d r%0d", sel, r), count_o, rl);
                u0 = ufl_seen;
                wr(1'b0, cw | RUN);
                ticks(sel, nt);
                wr(1'b0, cw);
                k = nt / dv;
                check($sformatf("R2 R3 R1 count sel%0d r%0d", sel, r), count_o, rl - (k % (rl + 1)));
                check($sformatf("R8 underflows sel%0d r%0d", sel, r), ufl_seen - u0, k / (rl + 1));
            end
        end

        // R4 stopped: ticks do nothing
        c0 = count_o; u0 = ufl_seen;
        ticks(0, 40);
        ticks(1, 40);
        check("R4 count holds while stopped", count_o, c0);
        check("R4 no underflow while stopped", ufl_seen - u0, 0);

        // R9 reload written while running is deferred
        wr(1'b0, 16'h0000);
        wr(1'b1, 16'd2);
        wr(1'b0, RUN);
        ticks(0, 1);
        check("R1 single decrement", count_o, 1);
        wr(1'b1, 16'd7);
        check("R9 running write leaves count", count_o, 1);
        u0 = ufl_seen;
        ticks(0, 2);
        check("R9 R8 deferred reload value", count_o, 7);
        check("R8 one pulse", ufl_seen - u0, 1);

        // R5 R6 event mode, falling edges
        wr(1'b0, 16'h0000);
        wr(1'b1, 16'd3);
        wr(1'b0, EVT | RUN | 16'h0006);
        ext_set(1'b0);
        check("R6 falling edge counts", count_o, 2);
        ext_set(1'b1);
        check("R6 rising edge ignored", count_o, 2);
        ticks(0, 40);
        ticks(1, 40);
        check("R5 source ticks ignored in event mode", count_o, 2);
        u0 = ufl_seen;
        for (int i = 0; i < 3; i++) begin
            ext_set(1'b0);
            ext_set(1'b1);
        end
        check("R8 event reload", count_o, 3);
        check("R8 event underflow", ufl_seen - u0, 1);

        // R6 rising polarity
        wr(1'b0, EVT | RISE | RUN);
        ext_set(1'b0);
        check("R6 falling ignored when rising selected", count_o, 3);
        ext_set(1'b1);
        check("R6 rising counts", count_o, 2);

        // R7 noise filter
        wr(1'b0, 16'h0000);
        wr(1'b1, 16'd10);
        wr(1'b0, EVT | FILT | RUN);
        smp(); smp();
        ext_set(1'b0);
        ext_set(1'b1);
        smp(); smp();
        check("R7 unsampled glitch ignored", count_o, 10);
        ext_set(1'b0);
        smp();
        ext_set(1'b1);
        smp(); smp();
        check("R7 single-sample glitch ignored", count_o, 10);
        ext_set(1'b0);
        smp();
        check("R7 one sample not enough", count_o, 10);
        smp();
        check("R7 stable change counts", count_o, 9);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule